// File: doc/BRIEF.md
# Circular Receive Memory Read Engine

This block drains one socket of a network protocol controller that sits on an 8-bit parallel register bus. It keeps asking the controller how many received bytes are waiting. When that number is nonzero and two readings agree, it fetches the socket's 16-bit read pointer. It then reads the waiting bytes out of the controller's circular receive memory and passes them on one at a time over a valid/ready byte port.

Each physical address is formed from the running pointer. The pointer is masked to the region size and added to the region base, so a read that lands on the last byte of the region is followed by a read at the base. When every byte has been fetched, the engine writes the advanced pointer back. It then issues the receive-acknowledge command and returns to polling.

Bus cycles use a plain request/acknowledge pair. The electrical timing of the bus is handled by a shared sequencer outside this block. The region base, region size, register addresses and command code are all parameters.

Top module: `rxr_read_engine`

## Requirements
- R1: While `rst_n` is low, `bus_req` and `out_valid` are 0. After reset the engine begins by polling.
- R2: Polling reads the byte-count register as two bus reads: high byte at `CNT_REG`, then low byte at `CNT_REG+1`. While the count reads zero, no other bus access is made and no byte is emitted.
- R3: A count is accepted only when two consecutive pair readings are equal and nonzero. A steady count therefore costs exactly four count reads. A count that changes between pairs costs a further pair.
- R4: After a count is accepted, and before any data read, the read pointer is read high byte first at `PTR_REG`, then low byte at `PTR_REG+1`.
- R5: Data byte k (counted from 0) is read at `RX_BASE + ((ptr + k) & (RX_SIZE-1))`. After the address `RX_BASE+RX_SIZE-1` the next read is at `RX_BASE`.
- R6: Exactly the accepted count of bytes is emitted, in read order, with no loss. `out_data` holds steady while `out_valid` is high and `out_ready` is low.
- R7: After the last data read, `(ptr + count) mod 65536` is written back: high byte to `PTR_REG`, then low byte to `PTR_REG+1`.
- R8: After the pointer write-back, `CMD_RECV` is written to `CMD_REG`, and the next access is a count read at `CNT_REG`.
- R9: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_ack`. In the cycle after an acknowledge, `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Controller address of the access |
| bus_wdata | output | DATA_W | Write byte |
| bus_ack | input | 1 | One-cycle completion of the requested access |
| bus_rdata | input | DATA_W | Read byte, valid with `bus_ack` |
| out_valid | output | 1 | Byte available downstream |
| out_data | output | DATA_W | Received byte |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The last received byte can still be held in the output stage, waiting for the downstream side, in the same cycles that the engine is writing the advanced pointer back on the bus. It may even be taken in the very cycle a write-back access is acknowledged. The bench provokes this by pulling `out_ready` high only one cycle in seven, and by running the bus with both zero and one cycle of acknowledge latency. It judges the result on two fronts: the full byte sequence must arrive intact and in order, and the logged bus trace must show the two pointer writes and the command with the expected values, in the expected order.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   // One state per bus access the engine can make.
   typedef enum logic [3:0] {
      ST_CNT_HI,
      ST_CNT_LO,
      ST_PTR_HI,
      ST_PTR_LO,
      ST_DATA,
      ST_WB_HI,
      ST_WB_LO,
      ST_CMD
   } rxr_state_e;

endpackage

// File: rtl/rxr_addr_map.sv
// Maps a 16-bit ring pointer onto the physical address of the receive region.
module rxr_addr_map #(
   parameter int                ADDR_W  = 16,
   parameter int                CNT_W   = 16,
   parameter logic [ADDR_W-1:0] RX_BASE = 'h6000,
   parameter int                RX_SIZE = 2048
) (
   input  logic [CNT_W-1:0]  ptr,
   output logic [ADDR_W-1:0] phys
);

   localparam int OFF_W = $clog2(RX_SIZE);

   logic [OFF_W-1:0] off;
   logic             unused_ptr_bits;

   // Region size is a power of two, so the mask is a slice.
   assign off             = ptr[OFF_W-1:0];
   assign unused_ptr_bits = ^ptr;

   generate
      if ((RX_BASE % RX_SIZE) == 0) begin : g_aligned
         assign phys = RX_BASE | ADDR_W'(off);
      end else begin : g_offset
         assign phys = RX_BASE + ADDR_W'(off);
      end
   endgenerate

endmodule

// File: rtl/rxr_byte_stage.sv
// Single-entry holding stage between the bus and the downstream byte port.
module rxr_byte_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= load_data;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R6: a new byte never lands on an undelivered one.
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);

   // R6: a stalled byte stays put.
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/rxr_read_engine.sv
module rxr_read_engine
   import rxr_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 8,
   parameter int                CNT_W    = 16,
   parameter logic [ADDR_W-1:0] RX_BASE  = 'h6000,
   parameter int                RX_SIZE  = 2048,
   parameter logic [ADDR_W-1:0] CNT_REG  = 'h0126,
   parameter logic [ADDR_W-1:0] PTR_REG  = 'h0128,
   parameter logic [ADDR_W-1:0] CMD_REG  = 'h0101,
   parameter logic [DATA_W-1:0] CMD_RECV = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);

   localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] RX_TOP = RX_BASE + ADDR_W'(RX_SIZE - 1);

   // Elaboration-time parameter checks.
   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("rxr_read_engine: DATA_W must be 8");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt_w
         $error("rxr_read_engine: CNT_W must be two bus bytes");
      end
      if (RX_SIZE < 2 || (RX_SIZE & (RX_SIZE - 1)) != 0) begin : g_bad_size
         $error("rxr_read_engine: RX_SIZE must be a power of two, at least 2");
      end
      if (RX_SIZE > (1 << CNT_W)) begin : g_bad_span
         $error("rxr_read_engine: RX_SIZE exceeds pointer range");
      end
      if ((longint'(RX_BASE) + longint'(RX_SIZE)) > (longint'(1) << ADDR_W)) begin : g_bad_region
         $error("rxr_read_engine: receive region exceeds address space");
      end
   endgenerate

   rxr_state_e        state_q;
   logic              req_q;
   logic [DATA_W-1:0] cnt_hi_q;
   logic [CNT_W-1:0]  cnt_prev_q;
   logic              have_prev_q;
   logic [CNT_W-1:0]  len_q;
   logic [CNT_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  idx_q;

   logic [CNT_W-1:0]  cnt_now;
   logic [CNT_W-1:0]  end_ptr;
   logic [CNT_W-1:0]  rd_ptr;
   logic [ADDR_W-1:0] data_addr;
   logic              take;
   logic              stage_load;
   logic              can_issue;

   assign cnt_now    = {cnt_hi_q, bus_rdata};
   assign end_ptr    = ptr_q + len_q;
   assign rd_ptr     = ptr_q + idx_q;
   assign take       = req_q && bus_ack;
   assign stage_load = take && (state_q == ST_DATA);
   assign can_issue  = (state_q != ST_DATA) || !out_valid;

   rxr_addr_map #(
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .RX_BASE (RX_BASE),
      .RX_SIZE (RX_SIZE)
   ) i_addr_map (
      .ptr  (rd_ptr),
      .phys (data_addr)
   );

   rxr_byte_stage #(
      .DATA_W (DATA_W)
   ) i_byte_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (stage_load),
      .load_data (bus_rdata),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

   // Sequencer: one bus access per state, advanced on acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_CNT_HI;
         req_q       <= 1'b0;
         cnt_hi_q    <= '0;
         cnt_prev_q  <= '0;
         have_prev_q <= 1'b0;
         len_q       <= '0;
         ptr_q       <= '0;
         idx_q       <= '0;
      end else if (take) begin
         req_q <= 1'b0;
         case (state_q)
            ST_CNT_HI: begin
               cnt_hi_q <= bus_rdata;
               state_q  <= ST_CNT_LO;
            end
            ST_CNT_LO: begin
               if (have_prev_q && cnt_now == cnt_prev_q && cnt_now != '0) begin
                  len_q   <= cnt_now;
                  state_q <= ST_PTR_HI;
               end else begin
                  state_q <= ST_CNT_HI;
               end
               cnt_prev_q  <= cnt_now;
               have_prev_q <= 1'b1;
            end
            ST_PTR_HI: begin
               ptr_q   <= {bus_rdata, ptr_q[DATA_W-1:0]};
               state_q <= ST_PTR_LO;
            end
            ST_PTR_LO: begin
               ptr_q   <= {ptr_q[CNT_W-1:DATA_W], bus_rdata};
               idx_q   <= '0;
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               idx_q <= idx_q + ONE_C;
               if (idx_q + ONE_C == len_q) begin
                  state_q <= ST_WB_HI;
               end
            end
            ST_WB_HI: state_q <= ST_WB_LO;
            ST_WB_LO: state_q <= ST_CMD;
            ST_CMD: begin
               have_prev_q <= 1'b0;
               state_q     <= ST_CNT_HI;
            end
            default: state_q <= ST_CNT_HI;
         endcase
      end else if (!req_q && can_issue) begin
         req_q <= 1'b1;
      end
   end

   // Access decode.
   always_comb begin
      bus_we    = 1'b0;
      bus_wdata = '0;
      bus_addr  = CNT_REG;
      case (state_q)
         ST_CNT_HI: bus_addr = CNT_REG;
         ST_CNT_LO: bus_addr = CNT_REG + ONE_A;
         ST_PTR_HI: bus_addr = PTR_REG;
         ST_PTR_LO: bus_addr = PTR_REG + ONE_A;
         ST_DATA:   bus_addr = data_addr;
         ST_WB_HI: begin
            bus_we    = 1'b1;
            bus_addr  = PTR_REG;
            bus_wdata = end_ptr[CNT_W-1:DATA_W];
         end
         ST_WB_LO: begin
            bus_we    = 1'b1;
            bus_addr  = PTR_REG + ONE_A;
            bus_wdata = end_ptr[DATA_W-1:0];
         end
         ST_CMD: begin
            bus_we    = 1'b1;
            bus_addr  = CMD_REG;
            bus_wdata = CMD_RECV;
         end
         default: bus_addr = CNT_REG;
      endcase
   end

   assign bus_req = req_q;

   // Checker state: last data address and data reads in the current burst.
   logic [ADDR_W-1:0] chk_last_q;
   logic              chk_have_q;
   logic [CNT_W-1:0]  chk_reads_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_last_q  <= '0;
         chk_have_q  <= 1'b0;
         chk_reads_q <= '0;
      end else if (take && state_q == ST_PTR_LO) begin
         chk_have_q  <= 1'b0;
         chk_reads_q <= '0;
      end else if (stage_load) begin
         chk_last_q  <= bus_addr;
         chk_have_q  <= 1'b1;
         chk_reads_q <= chk_reads_q + ONE_C;
      end
   end

   // R9: request is released after each acknowledge.
   p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> !bus_req);

   // R9: an access is held unchanged until acknowledged.
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));

   // R5: consecutive data reads step by one and wrap from the top to the base.
   p_wrap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && state_q == ST_DATA && chk_have_q) |->
         (bus_addr == ((chk_last_q == RX_TOP) ? RX_BASE : chk_last_q + ONE_A)));

   // R6: the write-back starts only after exactly the accepted count of reads.
   p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && state_q == ST_WB_HI) |-> (chk_reads_q == len_q));

endmodule

// File: tb/test_rxr_read_engine.sv
module test_rxr_read_engine;

   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] T_BASE     = 16'h6030;
   localparam int          T_SIZE     = 64;
   localparam logic [15:0] T_CNT      = 16'h0126;
   localparam logic [15:0] T_PTR      = 16'h0128;
   localparam logic [15:0] T_CMD      = 16'h0101;
   localparam logic [7:0]  T_RECV     = 8'h40;

   logic        clk;
   logic        rst_n;
   logic        bus_req;
   logic        bus_we;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_ack;
   logic [7:0]  bus_rdata;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready;

   rxr_read_engine #(
      .RX_BASE  (T_BASE),
      .RX_SIZE  (T_SIZE),
      .CNT_REG  (T_CNT),
      .PTR_REG  (T_PTR),
      .CMD_REG  (T_CMD),
      .CMD_RECV (T_RECV)
   ) i_rxr_read_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

   int          total = 0;
   int          bad   = 0;
   bit          done  = 0;
   logic [15:0] cnt_val = 16'h0000;
   logic [15:0] ptr_val = 16'h0000;
   int          lat_cfg = 0;
   int          rmode   = 0;
   bit          arm_pending = 0;
   logic [15:0] arm_cnt  = 16'h0000;
   bit          torn_on  = 0;
   logic [15:0] torn_new = 16'h0000;
   int          hi_reads = 0;
   bit          recv_seen = 0;
   logic        log_we   [256];
   logic [15:0] log_addr [256];
   logic [7:0]  log_data [256];
   int          n_log = 0;
   logic [7:0]  rx_bytes [256];
   int          rx_n = 0;
   int          cyc  = 0;

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   function automatic logic [15:0] exp_addr(input logic [15:0] p, input int k);
      logic [15:0] s;
      s = p + 16'(k);
      return T_BASE + (s & 16'(T_SIZE - 1));
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Controller model: registers, computed ring contents, access log.
   initial begin
      int wcnt;
      wcnt      = 0;
      bus_ack   = 1'b0;
      bus_rdata = 8'h00;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (wcnt >= lat_cfg) begin
               wcnt = 0;
               if (!bus_we && bus_addr == T_CNT) begin
                  if (arm_pending) begin
                     cnt_val     = arm_cnt;
                     arm_pending = 0;
                     n_log       = 0;
                     hi_reads    = 0;
                  end else if (torn_on && hi_reads == 1) begin
                     cnt_val = torn_new;
                     torn_on = 0;
                  end
                  hi_reads++;
               end
               if (n_log < 256) begin
                  log_we[n_log]   = bus_we;
                  log_addr[n_log] = bus_addr;
                  log_data[n_log] = bus_we ? bus_wdata : 8'h00;
                  n_log++;
               end
               if (bus_we) begin
                  if (bus_addr == T_PTR) ptr_val[15:8] = bus_wdata;
                  else if (bus_addr == T_PTR + 16'd1) ptr_val[7:0] = bus_wdata;
                  else if (bus_addr == T_CMD && bus_wdata == T_RECV) begin
                     recv_seen = 1;
                     cnt_val   = 16'h0000;
                  end
               end else begin
                  if (bus_addr == T_CNT) bus_rdata = cnt_val[15:8];
                  else if (bus_addr == T_CNT + 16'd1) bus_rdata = cnt_val[7:0];
                  else if (bus_addr == T_PTR) bus_rdata = ptr_val[15:8];
                  else if (bus_addr == T_PTR + 16'd1) bus_rdata = ptr_val[7:0];
                  else bus_rdata = mem_byte(bus_addr);
               end
               bus_ack = 1'b1;
            end else begin
               wcnt++;
            end
         end
      end
   end

   // Downstream consumer with a selectable ready pattern.
   initial begin
      bit         pv;
      bit         pr;
      logic [7:0] pd;
      pv = 0;
      pr = 0;
      pd = 8'h00;
      out_ready = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n && pv && !pr) begin
            check(out_valid && out_data == pd, "R6 stalled byte held",
                  {23'd0, out_valid, out_data}, {24'd1, pd});
         end
         case (rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 2) == 0;
            default: out_ready = (cyc % 7) == 0;
         endcase
         if (out_valid && out_ready) begin
            if (rx_n < 256) rx_bytes[rx_n] = out_data;
            rx_n++;
         end
         pv = out_valid;
         pr = out_ready;
         pd = out_data;
      end
   end

   task automatic run_case(input logic [15:0] p, input logic [15:0] c, input int lat,
                           input int rm, input logic [15:0] tn);
      int          w;
      int          eff;
      int          nc;
      int          bi;
      bit          ok;
      logic [15:0] endp;
      logic [15:0] bad_a;
      ptr_val   = p;
      lat_cfg   = lat;
      rmode     = rm;
      rx_n      = 0;
      recv_seen = 0;
      torn_new  = tn;
      torn_on   = (tn != 16'h0000);
      arm_cnt   = c;
      arm_pending = 1;
      eff  = (tn != 16'h0000) ? int'(tn) : int'(c);
      nc   = (tn != 16'h0000) ? 6 : 4;
      endp = p + 16'(eff);
      w = 0;
      while (!recv_seen && w < 20000) begin
         @(negedge clk);
         w++;
      end
      check(recv_seen, "R8 receive command issued", {31'd0, recv_seen}, 32'd1);
      w = 0;
      while (rx_n < eff && w < 5000) begin
         @(negedge clk);
         w++;
      end
      repeat (8) @(negedge clk);
      // R3: exactly nc count reads, alternating high then low.
      ok = (n_log > nc + 2 + eff + 3);
      for (int i = 0; i < nc; i++) begin
         if (log_we[i] || log_addr[i] != ((i % 2 == 1) ? T_CNT + 16'd1 : T_CNT)) ok = 0;
      end
      check(ok, "R3 stable count read pairs", 32'(n_log), 32'(nc));
      // R4: pointer read high then low.
      check(!log_we[nc] && log_addr[nc] == T_PTR && !log_we[nc+1]
            && log_addr[nc+1] == T_PTR + 16'd1, "R4 pointer read order",
            {log_addr[nc], log_addr[nc+1]}, {T_PTR, T_PTR + 16'd1});
      // R5: data addresses with wrap.
      ok = 1;
      bad_a = 16'h0000;
      for (int k = 0; k < eff; k++) begin
         if (log_we[nc+2+k] || log_addr[nc+2+k] != exp_addr(p, k)) begin
            if (ok) bad_a = log_addr[nc+2+k];
            ok = 0;
         end
      end
      check(ok, "R5 data read addresses", 32'(bad_a), 32'(exp_addr(p, 0)));
      // R7: pointer write-back.
      bi = nc + 2 + eff;
      check(log_we[bi] && log_addr[bi] == T_PTR && log_data[bi] == endp[15:8]
            && log_we[bi+1] && log_addr[bi+1] == T_PTR + 16'd1
            && log_data[bi+1] == endp[7:0], "R7 pointer write-back",
            {log_data[bi], log_data[bi+1]}, 32'(endp));
      check(ptr_val == endp, "R7 advanced pointer value", 32'(ptr_val), 32'(endp));
      // R8: command then polling resumes.
      check(log_we[bi+2] && log_addr[bi+2] == T_CMD && log_data[bi+2] == T_RECV
            && !log_we[bi+3] && log_addr[bi+3] == T_CNT, "R8 command and resume",
            {log_addr[bi+2], 8'h00, log_data[bi+2]}, {T_CMD, 8'h00, T_RECV});
      // R6: delivered bytes.
      ok = (rx_n == eff);
      for (int k = 0; k < eff && k < rx_n; k++) begin
         if (rx_bytes[k] != mem_byte(exp_addr(p, k))) ok = 0;
      end
      check(ok, "R6 delivered byte stream", 32'(rx_n), 32'(eff));
   endtask

   initial begin
      logic [15:0] ptrs[6];
      logic [15:0] cnts[3];
      bit          only_poll;
      ptrs = '{16'h0000, 16'h0001, 16'h003E, 16'h003F, 16'hFFFF, 16'h7FC3};
      cnts = '{16'd1, 16'd3, 16'd64};
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      // R1: quiet during reset.
      check(!bus_req && !out_valid, "R1 reset outputs", {30'd0, bus_req, out_valid}, 32'd0);
      rst_n = 1'b1;
      repeat (60) @(negedge clk);
      // R2: zero count polls only the count register.
      only_poll = (n_log > 4);
      for (int i = 0; i < n_log && i < 256; i++) begin
         if (log_we[i] || (log_addr[i] != T_CNT && log_addr[i] != T_CNT + 16'd1)) only_poll = 0;
      end
      check(only_poll && rx_n == 0, "R2 zero count polling only", 32'(rx_n), 32'd0);
      check(log_addr[0] == T_CNT && log_addr[1] == T_CNT + 16'd1, "R2 count read high first",
            {log_addr[0], log_addr[1]}, {T_CNT, T_CNT + 16'd1});
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 3; b++) begin
            for (int l = 0; l < 2; l++) begin
               for (int r = 0; r < 3; r++) begin
                  run_case(ptrs[a], cnts[b], l, r, 16'h0000);
               end
            end
         end
      end
      // R3: count changes between pairs; the later value must be used.
      run_case(16'h003D, 16'd5, 0, 0, 16'd3);
      run_case(16'h1236, 16'd9, 1, 2, 16'd2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule